// File: doc/BRIEF.md
# Sleep-Mode Entry and Exit Sequencer

This block sits beside the access pipeline of a synchronous memory and manages its low-power sleep mode. A sleep request arrives asynchronously and active high; the block brings it into the clock domain through a two-flop synchroniser. It then steps through a fixed entry sequence, holds the sleep state while the request stays high, and runs a fixed recovery sequence once the request falls. The state is exported, together with an access-allowed signal for the pipeline, a force-high-Z signal for the data output drivers, and a one-cycle abort pulse that marks any access in flight as invalid.

The block also watches the access protocol around sleep. The device has to be deselected when sleep starts. During recovery no chip select and no address strobe may be active. Either breach sets a sticky violation flag, one flag per cause, and only reset clears it. Memory contents and power gating are handled outside the block.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: Reset (rst_ni low) puts state_o at AWAKE (2'd0), access_ok_o at 1, and dq_hiz_o, abort_o, asleep_o, viol_entry_o and viol_recov_o at 0.
- R2: sleep_req_i passes through a two-stage synchroniser. A request that is driven high between edges is seen by the state machine only at the third rising edge after it is driven, so the state is still AWAKE after two edges.
- R3: While AWAKE with the synchronised request high, the state goes to ENTERING (2'd1). It stays there for exactly ENTRY_CYC (default 2) cycles and then goes to ASLEEP (2'd2), where asleep_o is 1.
- R4: While ASLEEP with the synchronised request low, the state goes to RECOVERING (2'd3). It stays there for exactly EXIT_CYC (default 2) cycles and then returns to AWAKE.
- R5: abort_o is 1 only in the first ENTERING cycle. It marks any pending access as invalid.
- R6: access_ok_o is 1 only in AWAKE.
- R7: dq_hiz_o is 1 in ENTERING, ASLEEP and RECOVERING, and 0 in AWAKE.
- R8: If dev_busy_i is 1 in the cycle in which AWAKE moves to ENTERING, viol_entry_o becomes 1 from the next edge.
- R9: If any bit of cs_act_i or strb_act_i is 1 in a RECOVERING cycle, viol_recov_o becomes 1 from the next edge. Selects and strobes seen in other states set no flag.
- R10: Both violation flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous sleep request, active high |
| dev_busy_i | input | 1 | Device selected or access pending |
| cs_act_i | input | NUM_CS | Chip selects, each normalised to active high |
| strb_act_i | input | NUM_STRB | Address strobes, each normalised to active high |
| state_o | output | 2 | Sequencer state (AWAKE=0, ENTERING=1, ASLEEP=2, RECOVERING=3) |
| asleep_o | output | 1 | In the ASLEEP state |
| access_ok_o | output | 1 | New accesses allowed |
| dq_hiz_o | output | 1 | Force the data outputs to high-Z |
| abort_o | output | 1 | Pending access is invalid (one cycle) |
| viol_entry_o | output | 1 | Sticky: sleep entered while the device was busy |
| viol_recov_o | output | 1 | Sticky: select or strobe active during recovery |

## Verification
The bench measures the exact latency from the request pin to ENTERING, ASLEEP and back to AWAKE. A synchroniser with one stage too many or too few, or a counter that is off by one, moves the state change by one edge and shows up as a mismatch. It drops the request in the middle of entry so that ASLEEP lasts a single cycle, and it raises the request during recovery; a design that cuts either sequence short or skips it disagrees with the cycle model in the bench. Selects and strobes are driven active while asleep and again during recovery. A design that checks the wrong window raises the recovery flag at the wrong time or never raises it. The bench also confirms that both flags survive many quiet cycles and clear only on reset.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } slp_state_e;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int EXIT_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  output slp_state_e state_o,
  output logic       entry_evt_o,
  output logic       first_enter_o,
  output logic       in_recov_o
);
  localparam int MAXC  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

  slp_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_AWAKE: if (req_i) begin
        st_d  = ST_ENTER;
        cnt_d = '0;
      end
      ST_ENTER: begin
        if (cnt_q == ENTRY_LAST) st_d = ST_ASLEEP;
        else                     cnt_d = cnt_q + 1'b1;
      end
      ST_ASLEEP: if (!req_i) begin
        st_d  = ST_RECOVER;
        cnt_d = '0;
      end
      ST_RECOVER: begin
        if (cnt_q == EXIT_LAST) st_d = ST_AWAKE;
        else                    cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q  <= ST_AWAKE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end

  assign state_o       = st_q;
  assign entry_evt_o   = (st_q == ST_AWAKE) && req_i;
  assign first_enter_o = (st_q == ST_ENTER) && (cnt_q == '0);
  assign in_recov_o    = (st_q == ST_RECOVER);

  AST_ASLEEP_VIA_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ASLEEP && $past(st_q) != ST_ASLEEP) |-> $past(st_q) == ST_ENTER); // R3
  AST_AWAKE_VIA_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_AWAKE && $past(st_q) != ST_AWAKE) |-> $past(st_q) == ST_RECOVER); // R4
  AST_STAY_AWAKE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_AWAKE && !req_i) |=> st_q == ST_AWAKE); // R3
  AST_HOLD_ASLEEP_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ASLEEP && req_i) |=> st_q == ST_ASLEEP); // R4
endmodule

// File: rtl/sleep_viol.sv
module sleep_viol #(
  parameter int NUM_CS   = 3,
  parameter int NUM_STRB = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                entry_evt_i,
  input  logic                dev_busy_i,
  input  logic                recov_i,
  input  logic [NUM_CS-1:0]   cs_act_i,
  input  logic [NUM_STRB-1:0] strb_act_i,
  output logic                viol_entry_o,
  output logic                viol_recov_o
);
  logic ent_q, rec_q;
  logic any_sel;

  assign any_sel = (|cs_act_i) || (|strb_act_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ent_q <= 1'b0;
      rec_q <= 1'b0;
    end else begin
      if (entry_evt_i && dev_busy_i) ent_q <= 1'b1;
      if (recov_i && any_sel)        rec_q <= 1'b1;
    end

  assign viol_entry_o = ent_q;
  assign viol_recov_o = rec_q;

  AST_ENTRY_VIOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_evt_i && dev_busy_i) |=> viol_entry_o); // R8
  AST_RECOV_VIOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recov_i && any_sel) |=> viol_recov_o); // R9
  AST_VIOL_ENTRY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_entry_o |=> viol_entry_o); // R10
  AST_VIOL_RECOV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_recov_o |=> viol_recov_o); // R10
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int EXIT_CYC    = 2,
  parameter int NUM_CS      = 3,
  parameter int NUM_STRB    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_req_i,
  input  logic                dev_busy_i,
  input  logic [NUM_CS-1:0]   cs_act_i,
  input  logic [NUM_STRB-1:0] strb_act_i,
  output logic [1:0]          state_o,
  output logic                asleep_o,
  output logic                access_ok_o,
  output logic                dq_hiz_o,
  output logic                abort_o,
  output logic                viol_entry_o,
  output logic                viol_recov_o
);
  logic       req_s;
  slp_state_e st;
  logic       entry_evt, first_enter, in_recov;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(sleep_req_i),
    .sync_o (req_s)
  );

  sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_s),
    .state_o      (st),
    .entry_evt_o  (entry_evt),
    .first_enter_o(first_enter),
    .in_recov_o   (in_recov)
  );

  sleep_viol #(.NUM_CS(NUM_CS), .NUM_STRB(NUM_STRB)) u_viol (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entry_evt_i (entry_evt),
    .dev_busy_i  (dev_busy_i),
    .recov_i     (in_recov),
    .cs_act_i    (cs_act_i),
    .strb_act_i  (strb_act_i),
    .viol_entry_o(viol_entry_o),
    .viol_recov_o(viol_recov_o)
  );

  assign state_o     = st;
  assign asleep_o    = (st == ST_ASLEEP);
  assign access_ok_o = (st == ST_AWAKE);
  assign dq_hiz_o    = (st != ST_AWAKE);
  assign abort_o     = first_enter;

  AST_ABORT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R5
  AST_ABORT_AFTER_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> $past(access_ok_o)); // R5
  AST_ASLEEP_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> (dq_hiz_o && !access_ok_o)); // R7
  AST_ENTRY_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(access_ok_o) |-> $past(req_s)); // R2
endmodule

// File: tb/sleep_seq_ctrl_tb_top.sv
module sleep_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 3;
  localparam int NST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, busy = 1'b0;
  logic [NCS-1:0] cs = '0;
  logic [NST-1:0] stb = '0;
  logic [1:0] state;
  logic asleep, acc_ok, hiz, abort_w, v_ent, v_rec;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sleep_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .dev_busy_i(busy),
    .cs_act_i(cs), .strb_act_i(stb), .state_o(state), .asleep_o(asleep),
    .access_ok_o(acc_ok), .dq_hiz_o(hiz), .abort_o(abort_w),
    .viol_entry_o(v_ent), .viol_recov_o(v_rec)
  );

  // cycle model built from the requirements
  logic m_s1, m_s2, m_ve, m_vr;
  logic [1:0] m_st;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_st <= 0; m_cnt <= 0; m_ve <= 0; m_vr <= 0;
    end else begin
      m_s1 <= req; m_s2 <= m_s1;
      case (m_st)
        2'd0: if (m_s2) begin m_st <= 2'd1; m_cnt <= 0; if (busy) m_ve <= 1; end
        2'd1: if (m_cnt == 1) m_st <= 2'd2; else m_cnt <= m_cnt + 1;
        2'd2: if (!m_s2) begin m_st <= 2'd3; m_cnt <= 0; end
        default: begin
          if ((|cs) || (|stb)) m_vr <= 1;
          if (m_cnt == 1) m_st <= 2'd0; else m_cnt <= m_cnt + 1;
        end
      endcase
    end
  end

  function automatic logic exp_abort(logic [1:0] s, int c);
    return (s == 2'd1) && (c == 0);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R3 R4 state", {6'd0, state}, {6'd0, m_st});
    chk("R3 asleep", {7'd0, asleep}, {7'd0, m_st == 2'd2});
    chk("R6 access_ok", {7'd0, acc_ok}, {7'd0, m_st == 2'd0});
    chk("R7 hiz", {7'd0, hiz}, {7'd0, m_st != 2'd0});
    chk("R5 abort", {7'd0, abort_w}, {7'd0, exp_abort(m_st, m_cnt)});
    chk("R8 viol_entry", {7'd0, v_ent}, {7'd0, m_ve});
    chk("R9 viol_recov", {7'd0, v_rec}, {7'd0, m_vr});
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    cmp_model();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req = 0; busy = 0; cs = '0; stb = '0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1 reset values
    chk("R1 state", {6'd0, state}, 8'd0);
    chk("R1 access_ok", {7'd0, acc_ok}, 8'd1);
    chk("R1 hiz/abort/asleep", {5'd0, hiz, abort_w, asleep}, 8'd0);
    chk("R1 viol", {6'd0, v_ent, v_rec}, 8'd0);

    // entry latency
    req = 1;
    tick(); tick();
    chk("R2 still awake after two edges", {6'd0, state}, 8'd0);
    tick();
    chk("R3 entering", {6'd0, state}, 8'd1);
    chk("R5 abort first entry cycle", {7'd0, abort_w}, 8'd1);
    chk("R6 no access entering", {7'd0, acc_ok}, 8'd0);
    chk("R7 hiz entering", {7'd0, hiz}, 8'd1);
    tick();
    chk("R3 entering second cycle", {6'd0, state}, 8'd1);
    chk("R5 abort single", {7'd0, abort_w}, 8'd0);
    tick();
    chk("R3 asleep after two entry cycles", {6'd0, state}, 8'd2);
    chk("R3 asleep flag", {7'd0, asleep}, 8'd1);
    // selects while asleep are ignored
    cs = '1; stb = '1;
    tick(); tick();
    chk("R9 no flag outside recovery", {7'd0, v_rec}, 8'd0);
    cs = '0; stb = '0;
    // exit latency
    req = 0;
    tick(); tick();
    chk("R4 still asleep after two edges", {6'd0, state}, 8'd2);
    tick();
    chk("R4 recovering", {6'd0, state}, 8'd3);
    chk("R7 hiz recovering", {7'd0, hiz}, 8'd1);
    tick();
    chk("R4 recovering second cycle", {6'd0, state}, 8'd3);
    tick();
    chk("R4 awake after recovery", {6'd0, state}, 8'd0);
    chk("R6 access restored", {7'd0, acc_ok}, 8'd1);

    // entry while busy
    busy = 1; req = 1;
    tick(); tick(); tick();
    chk("R8 entry violation set", {7'd0, v_ent}, 8'd1);
    busy = 0;
    tick(); tick();
    // strobe during recovery
    req = 0;
    tick(); tick(); tick();
    chk("R4 recovering again", {6'd0, state}, 8'd3);
    stb = 2'b01;
    tick();
    chk("R9 recovery violation set", {7'd0, v_rec}, 8'd1);
    stb = '0;
    for (int i = 0; i < 20; i++) tick();
    chk("R10 entry flag sticky", {7'd0, v_ent}, 8'd1);
    chk("R10 recovery flag sticky", {7'd0, v_rec}, 8'd1);
    do_reset();
    chk("R10 flags cleared by reset", {6'd0, v_ent, v_rec}, 8'd0);

    // random phase, compared each cycle with the model
    for (int t = 0; t < 150; t++) begin
      do_reset();
      for (int c = 0; c < 80; c++) begin
        if ($urandom_range(11) == 0) req = ~req;
        busy = ($urandom_range(3) == 0);
        for (int b = 0; b < NCS; b++) cs[b] = ($urandom_range(15) == 0);
        for (int b = 0; b < NST; b++) stb[b] = ($urandom_range(15) == 0);
        tick();
      end
    end
    summary();
  end
endmodule